// File: doc/BRIEF.md
# Indexed Load/Store Address Unit

This unit runs the memory-access instructions of a small 16-bit processor with eight general registers. A decoded operation names a data register, a base register and an index register. The unit reads all three from the register file and forms a byte address as base plus index. The index can be used as it is, stepped up after the access, or stepped down before the address is formed. The step equals the access size: one for a byte, two for a word.

The unit sends a single request to a synchronous memory port and waits for a response strobe. It then writes the loaded value and the modified index back through two register-file write ports. It can also place an 8-bit immediate into the low byte of a register without any memory traffic. Only one operation is in flight at a time. `op_ready` is high when a new operation can be taken.

Top module: `idx_ldst_unit`

## Requirements
- R1: With op_mode 00 (or 11), mem_addr is rf[base] + rf[index], and the index write port stays idle, so the index register keeps its value.
- R2: With op_mode 01, mem_addr is rf[base] + the original rf[index], and the index register is then written with index + step.
- R3: With op_mode 10, the index register is first reduced by the step, mem_addr is rf[base] + the reduced index, and the reduced value is written back to the index register.
- R4: The step is 1 when op_word is 0 (byte) and 2 when op_word is 1 (word), for both increment and decrement.
- R5: A byte load (op_kind 01, op_word 0) takes the byte from mem_rdata[7:0] and writes it zero-extended, ignoring mem_rdata[15:8].
- R6: Word transfers are big-endian: mem_rdata[15:8] and mem_wdata[15:8] carry the byte at mem_addr, and bits [7:0] carry the byte at mem_addr+1. A byte store (op_kind 10, op_word 0) drives the source register's low byte on mem_wdata[7:0] and zero on mem_wdata[15:8].
- R7: An immediate load (op_kind 00) writes op_imm into the low byte of the destination register, leaves its upper byte unchanged, and issues no memory request.
- R8: All address and index arithmetic wraps modulo 2^16.
- R9: When a load's destination register is also its auto-modified index register, only the loaded data is written, and the index write port stays idle.
- R10: For a memory operation, mem_req is a one-cycle pulse in the cycle after acceptance. Write-back happens in the cycle after mem_rvalid is sampled. op_ready stays low from acceptance until write-back completes.
- R11: After reset, op_ready is 1 and mem_req, rf_we_data and rf_we_index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Decoded operation present |
| op_ready | output | 1 | Unit idle, operation taken when op_valid is high |
| op_kind | input | 2 | 00 immediate load, 01 memory load, 10 memory store, 11 no effect |
| op_mode | input | 2 | 00 plain, 01 post-increment, 10 pre-decrement, 11 plain |
| op_word | input | 1 | 1 word access, 0 byte access |
| op_rd | input | 3 | Data register (load destination or store source) |
| op_rb | input | 3 | Base register |
| op_ri | input | 3 | Index register |
| op_imm | input | 8 | Immediate byte |
| rf_ra_base | output | 3 | Register-file read address, base |
| rf_ra_index | output | 3 | Register-file read address, index |
| rf_ra_data | output | 3 | Register-file read address, data register |
| rf_rd_base | input | 16 | Base register value |
| rf_rd_index | input | 16 | Index register value |
| rf_rd_data | input | 16 | Data register value |
| rf_we_data | output | 1 | Data write enable |
| rf_wa_data | output | 3 | Data write address |
| rf_wd_data | output | 16 | Data write value |
| rf_we_index | output | 1 | Index write enable |
| rf_wa_index | output | 3 | Index write address |
| rf_wd_index | output | 16 | Index write value |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 store, 0 load |
| mem_word | output | 1 | 1 word transfer, 0 byte transfer |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Store data |
| mem_rvalid | input | 1 | Memory response strobe |
| mem_rdata | input | 16 | Load data |

## Verification
An operation is taken at the edge where op_valid and op_ready are both high. The immediate write and the memory request, with its address and store data, appear in the next cycle. The loaded value and the index update appear in the cycle after mem_rvalid is sampled. The register file holds the new values one edge later, and op_ready is high again at that point. The bench drives inputs on falling edges and reads each port in the exact cycle given by this schedule. Between the request and the response it inserts a random wait of one to four cycles, checking that mem_req has dropped and op_ready is still low during that wait.

// File: rtl/idx_ldst_pkg.sv
// Shared encodings for the indexed load/store unit.
// Assumes the decoder supplies op_kind and op_mode with the values below.
package idx_ldst_pkg;
    typedef enum logic [1:0] {
        K_IMM   = 2'b00,
        K_LOAD  = 2'b01,
        K_STORE = 2'b10,
        K_NONE  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        M_PLAIN   = 2'b00,
        M_POSTINC = 2'b01,
        M_PREDEC  = 2'b10,
        M_PLAIN2  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EXEC,
        S_WAIT,
        S_DONE
    } state_e;
endpackage

// File: rtl/idx_ldst_agen.sv
// Effective-address and index-update arithmetic, purely combinational.
// Assumes byte addressing; the step is 1 for bytes and 2 for words, and
// every sum wraps at the width AW.
module idx_ldst_agen
    import idx_ldst_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base_val,
    input  logic [AW-1:0] index_val,
    input  mode_e         mode,
    input  logic          is_word,
    output logic [AW-1:0] eff_addr,
    output logic [AW-1:0] idx_new,
    output logic          idx_wr
);
    localparam logic [AW-1:0] STEP_BYTE = AW'(1);
    localparam logic [AW-1:0] STEP_WORD = AW'(2);

    logic [AW-1:0] step;
    logic [AW-1:0] idx_up;
    logic [AW-1:0] idx_dn;

    // Step size and both candidate index values.
    always_comb begin
        step   = is_word ? STEP_WORD : STEP_BYTE;
        idx_up = index_val + step;
        idx_dn = index_val - step;
    end

    // Pick the address offset and the written-back index by mode.
    always_comb begin
        case (mode)
            M_POSTINC: begin
                eff_addr = base_val + index_val;
                idx_new  = idx_up;
                idx_wr   = 1'b1;
            end
            M_PREDEC: begin
                eff_addr = base_val + idx_dn;
                idx_new  = idx_dn;
                idx_wr   = 1'b1;
            end
            default: begin
                eff_addr = base_val + index_val;
                idx_new  = index_val;
                idx_wr   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/idx_ldst_fmt.sv
// Data-lane formatting between registers and the memory port.
// Assumes the memory returns a byte on the low lane and a word with the
// byte at the lower address in the upper lane.
module idx_ldst_fmt #(
    parameter int DW = 16
) (
    input  logic            is_word,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [DW-1:0]   reg_src,
    input  logic [DW/2-1:0] imm,
    output logic [DW-1:0]   load_val,
    output logic [DW-1:0]   store_data,
    output logic [DW-1:0]   imm_merged
);
    localparam int LB = DW / 2;

    // Zero-extend byte loads and mask byte stores to the low lane.
    always_comb begin
        if (is_word) begin
            load_val   = mem_rdata;
            store_data = reg_src;
        end else begin
            load_val   = {{(DW-LB){1'b0}}, mem_rdata[LB-1:0]};
            store_data = {{(DW-LB){1'b0}}, reg_src[LB-1:0]};
        end
    end

    // Immediate replaces the low byte, upper byte kept.
    always_comb begin
        imm_merged = {reg_src[DW-1:LB], imm};
    end
endmodule

// File: rtl/idx_ldst_unit.sv
// Indexed load/store unit: accepts one decoded operation at a time,
// reads base/index/data registers, issues one memory transfer and writes
// loaded data and the updated index back. Assumes a register file with
// combinational reads and write ports sampled on the rising clock edge.
module idx_ldst_unit
    import idx_ldst_pkg::*;
#(
    parameter int RAW = 3,
    parameter int DW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    output logic            op_ready,
    input  logic [1:0]      op_kind,
    input  logic [1:0]      op_mode,
    input  logic            op_word,
    input  logic [RAW-1:0]  op_rd,
    input  logic [RAW-1:0]  op_rb,
    input  logic [RAW-1:0]  op_ri,
    input  logic [DW/2-1:0] op_imm,
    output logic [RAW-1:0]  rf_ra_base,
    output logic [RAW-1:0]  rf_ra_index,
    output logic [RAW-1:0]  rf_ra_data,
    input  logic [DW-1:0]   rf_rd_base,
    input  logic [DW-1:0]   rf_rd_index,
    input  logic [DW-1:0]   rf_rd_data,
    output logic            rf_we_data,
    output logic [RAW-1:0]  rf_wa_data,
    output logic [DW-1:0]   rf_wd_data,
    output logic            rf_we_index,
    output logic [RAW-1:0]  rf_wa_index,
    output logic [DW-1:0]   rf_wd_index,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_word,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_rvalid,
    input  logic [DW-1:0]   mem_rdata
);
    localparam int IW = DW / 2;

    state_e          state;
    kind_e           q_kind;
    mode_e           q_mode;
    logic            q_word;
    logic [RAW-1:0]  q_rd;
    logic [RAW-1:0]  q_rb;
    logic [RAW-1:0]  q_ri;
    logic [IW-1:0]   q_imm;
    logic [DW-1:0]   q_idx_new;
    logic            q_idx_wr;
    logic [DW-1:0]   q_load_val;

    logic [DW-1:0]   eff_addr;
    logic [DW-1:0]   idx_new;
    logic            idx_wr;
    logic [DW-1:0]   load_val;
    logic [DW-1:0]   store_data;
    logic [DW-1:0]   imm_merged;
    logic            is_mem_op;

    idx_ldst_agen #(.AW(DW)) agen_i (
        .base_val (rf_rd_base),
        .index_val(rf_rd_index),
        .mode     (q_mode),
        .is_word  (q_word),
        .eff_addr (eff_addr),
        .idx_new  (idx_new),
        .idx_wr   (idx_wr)
    );

    idx_ldst_fmt #(.DW(DW)) fmt_i (
        .is_word   (q_word),
        .mem_rdata (mem_rdata),
        .reg_src   (rf_rd_data),
        .imm       (q_imm),
        .load_val  (load_val),
        .store_data(store_data),
        .imm_merged(imm_merged)
    );

    // Memory operations are loads and stores; others finish in EXEC.
    always_comb begin
        is_mem_op = (q_kind == K_LOAD) || (q_kind == K_STORE);
    end

    // Sequencer: accept, execute, wait for response, write back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            q_kind     <= K_IMM;
            q_mode     <= M_PLAIN;
            q_word     <= 1'b0;
            q_rd       <= '0;
            q_rb       <= '0;
            q_ri       <= '0;
            q_imm      <= '0;
            q_idx_new  <= '0;
            q_idx_wr   <= 1'b0;
            q_load_val <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (op_valid) begin
                        q_kind <= kind_e'(op_kind);
                        q_mode <= mode_e'(op_mode);
                        q_word <= op_word;
                        q_rd   <= op_rd;
                        q_rb   <= op_rb;
                        q_ri   <= op_ri;
                        q_imm  <= op_imm;
                        state  <= S_EXEC;
                    end
                end
                S_EXEC: begin
                    q_idx_new <= idx_new;
                    q_idx_wr  <= idx_wr;
                    state     <= is_mem_op ? S_WAIT : S_IDLE;
                end
                S_WAIT: begin
                    if (mem_rvalid) begin
                        q_load_val <= load_val;
                        state      <= S_DONE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Handshake and register-file read addresses.
    always_comb begin
        op_ready    = (state == S_IDLE);
        rf_ra_base  = q_rb;
        rf_ra_index = q_ri;
        rf_ra_data  = q_rd;
    end

    // Memory request, issued in the cycle after acceptance.
    always_comb begin
        mem_req   = (state == S_EXEC) && is_mem_op;
        mem_we    = (q_kind == K_STORE);
        mem_word  = q_word;
        mem_addr  = eff_addr;
        mem_wdata = store_data;
    end

    // Write-back; loaded data wins over the index on a shared register.
    always_comb begin
        rf_we_data  = ((state == S_EXEC) && (q_kind == K_IMM)) ||
                      ((state == S_DONE) && (q_kind == K_LOAD));
        rf_wa_data  = q_rd;
        rf_wd_data  = (state == S_EXEC) ? imm_merged : q_load_val;
        rf_we_index = (state == S_DONE) && q_idx_wr &&
                      !((q_kind == K_LOAD) && (q_rd == q_ri));
        rf_wa_index = q_ri;
        rf_wd_index = q_idx_new;
    end

    // R10: an accepted memory operation raises the request next cycle.
    assert_req_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready && op_valid && (op_kind == 2'b01 || op_kind == 2'b10)) |=> mem_req);

    // R10: the request lasts exactly one cycle.
    assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10: the unit only becomes busy by accepting an operation.
    assert_busy_from_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(op_ready) |-> $past(op_valid));

    // R10 / R5: load data is written one cycle after the response.
    assert_wb_after_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && mem_rvalid && q_kind == K_LOAD) |=>
        (rf_we_data && rf_wd_data == $past(load_val)));

    // R9: both write ports never target the same register together.
    assert_data_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_data && rf_we_index) |-> (rf_wa_data != rf_wa_index));

    // R2 / R3: a store with an auto-modified index updates it at write-back.
    assert_store_index_upd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && mem_rvalid && q_kind == K_STORE && q_idx_wr) |=>
        rf_we_index);

    // R7: immediate loads never reach memory.
    assert_imm_no_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXEC && q_kind == K_IMM) |-> (!mem_req && rf_we_data));
endmodule

// File: tb/idx_ldst_unit_tb_top.sv
module idx_ldst_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [1:0]  op_kind = 2'b00;
    logic [1:0]  op_mode = 2'b00;
    logic        op_word = 1'b0;
    logic [2:0]  op_rd = '0, op_rb = '0, op_ri = '0;
    logic [7:0]  op_imm = '0;
    logic [2:0]  rf_ra_base, rf_ra_index, rf_ra_data;
    logic [15:0] rf_rd_base, rf_rd_index, rf_rd_data;
    logic        rf_we_data, rf_we_index;
    logic [2:0]  rf_wa_data, rf_wa_index;
    logic [15:0] rf_wd_data, rf_wd_index;
    logic        mem_req, mem_we, mem_word;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;

    logic [15:0] rf [8];
    logic [15:0] mreg [8];
    logic [7:0]  mem8 [256];
    logic        pre_we = 1'b0;
    logic [2:0]  pre_a = '0;
    logic [15:0] pre_d = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    idx_ldst_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .op_mode(op_mode), .op_word(op_word),
        .op_rd(op_rd), .op_rb(op_rb), .op_ri(op_ri), .op_imm(op_imm),
        .rf_ra_base(rf_ra_base), .rf_ra_index(rf_ra_index), .rf_ra_data(rf_ra_data),
        .rf_rd_base(rf_rd_base), .rf_rd_index(rf_rd_index), .rf_rd_data(rf_rd_data),
        .rf_we_data(rf_we_data), .rf_wa_data(rf_wa_data), .rf_wd_data(rf_wd_data),
        .rf_we_index(rf_we_index), .rf_wa_index(rf_wa_index), .rf_wd_index(rf_wd_index),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Bench register file: combinational reads, edge-sampled writes.
    assign rf_rd_base  = rf[rf_ra_base];
    assign rf_rd_index = rf[rf_ra_index];
    assign rf_rd_data  = rf[rf_ra_data];

    always @(posedge clk) begin
        if (pre_we) rf[pre_a] <= pre_d;
        if (rf_we_index) rf[rf_wa_index] <= rf_wd_index;
        if (rf_we_data)  rf[rf_wa_data]  <= rf_wd_data;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_a = a; pre_d = d;
        @(negedge clk);
        pre_we = 1'b0;
        mreg[a] = d;
    endtask

    function automatic logic [15:0] step_of(input logic w);
        return w ? 16'd2 : 16'd1;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [1:0] m, input logic w,
                                             input logic [15:0] b, input logic [15:0] x);
        return (m == 2'b10) ? (b + x - step_of(w)) : (b + x);
    endfunction

    function automatic logic [15:0] exp_index(input logic [1:0] m, input logic w,
                                              input logic [15:0] x);
        if (m == 2'b01) return x + step_of(w);
        if (m == 2'b10) return x - step_of(w);
        return x;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        if (m == 2'b01) return "R2 post-inc";
        if (m == 2'b10) return "R3 pre-dec";
        return "R1 plain";
    endfunction

    // Run one operation and check every port in its due cycle.
    task automatic do_op(input logic [1:0] k, input logic [1:0] m, input logic w,
                         input logic [2:0] rd, input logic [2:0] rb, input logic [2:0] ri,
                         input logic [7:0] imm, input int lat);
        logic [15:0] b, x, d, a, nx, lv, rdat;
        logic [7:0]  ai;
        logic        idx_exp;
        b  = mreg[rb];
        x  = mreg[ri];
        d  = mreg[rd];
        a  = exp_addr(m, w, b, x);
        nx = exp_index(m, w, x);
        ai = a[7:0];

        @(negedge clk);
        chk("R10 ready before issue", {31'd0, op_ready}, 32'd1);
        op_valid = 1'b1; op_kind = k; op_mode = m; op_word = w;
        op_rd = rd; op_rb = rb; op_ri = ri; op_imm = imm;
        @(negedge clk);
        op_valid = 1'b0;
        op_kind = 2'($urandom); op_rd = 3'($urandom);
        chk("R10 busy after accept", {31'd0, op_ready}, 32'd0);

        if (k == 2'b00) begin
            chk("R7 no memory request", {31'd0, mem_req}, 32'd0);
            chk("R7 data write enable", {31'd0, rf_we_data}, 32'd1);
            chk("R7 data write address", {29'd0, rf_wa_data}, {29'd0, rd});
            chk("R7 upper kept low replaced", {16'd0, rf_wd_data}, {16'd0, d[15:8], imm});
            chk("R7 index port idle", {31'd0, rf_we_index}, 32'd0);
            mreg[rd] = {d[15:8], imm};
        end else begin
            chk("R10 request one cycle after accept", {31'd0, mem_req}, 32'd1);
            chk(mode_tag(m), {16'd0, mem_addr}, {16'd0, a});
            chk("R6 direction", {31'd0, mem_we}, {31'd0, (k == 2'b10)});
            chk("R4 size", {31'd0, mem_word}, {31'd0, w});
            if (k == 2'b10)
                chk("R6 store lanes", {16'd0, mem_wdata},
                    {16'd0, (w ? d : {8'h00, d[7:0]})});
            if (k == 2'b01) begin
                rdat = w ? {mem8[ai], mem8[8'(ai + 8'd1)]} : {8'($urandom), mem8[ai]};
                lv   = w ? rdat : {8'h00, rdat[7:0]};
            end else begin
                rdat = 16'($urandom);
                lv   = 16'h0;
                if (w) begin
                    mem8[ai] = d[15:8];
                    mem8[8'(ai + 8'd1)] = d[7:0];
                end else begin
                    mem8[ai] = d[7:0];
                end
            end
            repeat (1 + lat) begin
                @(negedge clk);
                chk("R10 request is a pulse", {31'd0, mem_req}, 32'd0);
                chk("R10 busy while waiting", {31'd0, op_ready}, 32'd0);
            end
            mem_rvalid = 1'b1; mem_rdata = rdat;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = 16'($urandom);
            idx_exp = (m == 2'b01 || m == 2'b10) && !(k == 2'b01 && rd == ri);
            chk("R10 data write one cycle after response", {31'd0, rf_we_data},
                {31'd0, (k == 2'b01)});
            if (k == 2'b01) begin
                chk(w ? "R6 word load big-endian" : "R5 byte load zero-extend",
                    {16'd0, rf_wd_data}, {16'd0, lv});
                chk("R10 load write address", {29'd0, rf_wa_data}, {29'd0, rd});
            end
            if (k == 2'b01 && rd == ri && m != 2'b00 && m != 2'b11)
                chk("R9 index write suppressed", {31'd0, rf_we_index}, 32'd0);
            else if (m == 2'b00 || m == 2'b11)
                chk("R1 index untouched", {31'd0, rf_we_index}, 32'd0);
            else
                chk(mode_tag(m), {31'd0, rf_we_index}, 32'd1);
            if (idx_exp) begin
                chk("R4 index step", {16'd0, rf_wd_index}, {16'd0, nx});
                chk("R4 index address", {29'd0, rf_wa_index}, {29'd0, ri});
                mreg[ri] = nx;
            end
            if (k == 2'b01) mreg[rd] = lv;
        end

        @(negedge clk);
        chk("R10 ready after completion", {31'd0, op_ready}, 32'd1);
        chk("R9 destination register", {16'd0, rf[rd]}, {16'd0, mreg[rd]});
        chk(mode_tag(m), {16'd0, rf[ri]}, {16'd0, mreg[ri]});
        chk("R1 base register kept", {16'd0, rf[rb]}, {16'd0, mreg[rb]});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) mem8[i] = 8'($urandom);
        for (int i = 0; i < 8; i++) begin
            rf[i]   = 16'(i * 16'h1111);
            mreg[i] = 16'(i * 16'h1111);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ready after reset", {31'd0, op_ready}, 32'd1);
        chk("R11 no request after reset", {31'd0, mem_req}, 32'd0);
        chk("R11 no data write after reset", {31'd0, rf_we_data}, 32'd0);
        chk("R11 no index write after reset", {31'd0, rf_we_index}, 32'd0);

        // R8: base + index wraps past 0xFFFF.
        set_reg(3'd1, 16'hFFFF);
        set_reg(3'd2, 16'h0003);
        do_op(2'b01, 2'b00, 1'b1, 3'd4, 3'd1, 3'd2, 8'h00, 0);
        chk("R8 wrapped sum", {16'd0, mem_addr}, 32'h0000_0002);
        // R8 / R3: byte pre-decrement from zero gives 0xFFFF.
        set_reg(3'd2, 16'h0000);
        set_reg(3'd1, 16'h0010);
        do_op(2'b01, 2'b10, 1'b0, 3'd4, 3'd1, 3'd2, 8'h00, 1);
        chk("R8 index wraps down", {16'd0, rf[2]}, 32'h0000_FFFF);
        // R8 / R2: word post-increment from 0xFFFF gives 0x0001.
        set_reg(3'd2, 16'hFFFF);
        do_op(2'b10, 2'b01, 1'b1, 3'd5, 3'd1, 3'd2, 8'h00, 2);
        chk("R8 index wraps up", {16'd0, rf[2]}, 32'h0000_0001);
        // R9: load into its own auto-modified index.
        set_reg(3'd3, 16'h0040);
        do_op(2'b01, 2'b01, 1'b1, 3'd3, 3'd1, 3'd3, 8'h00, 0);
        do_op(2'b01, 2'b10, 1'b0, 3'd3, 3'd1, 3'd3, 8'h00, 3);
        // R7: immediate loads, including register 0 and 7.
        set_reg(3'd7, 16'hABCD);
        do_op(2'b00, 2'b00, 1'b0, 3'd7, 3'd0, 3'd0, 8'h5A, 0);
        do_op(2'b00, 2'b01, 1'b1, 3'd0, 3'd1, 3'd0, 8'hFF, 0);
        // R6: byte store masks the upper lane; word store then reload.
        do_op(2'b10, 2'b00, 1'b0, 3'd7, 3'd1, 3'd6, 8'h00, 1);
        do_op(2'b10, 2'b00, 1'b1, 3'd7, 3'd1, 3'd6, 8'h00, 0);
        do_op(2'b01, 2'b00, 1'b1, 3'd5, 3'd1, 3'd6, 8'h00, 0);
        chk("R6 reload equals stored word", {16'd0, rf[5]}, {16'd0, rf[7]});

        // Constrained random operations.
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 8) == 0)
                set_reg(3'($urandom), 16'($urandom));
            do_op(2'($urandom % 3), 2'($urandom % 4), 1'($urandom),
                  3'($urandom), 3'($urandom), 3'($urandom), 8'($urandom),
                  int'($urandom % 4));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule